// File: doc/BRIEF.md
# Measurement Register Bank Controller

This block keeps a small bank of wide measurement registers whose contents can only grow by accumulation. The host cannot store a value in a register. It can read any register, and it can ask for one of two operations. The first folds a new digest into a register. The second zeroes a register, and only the dynamic registers accept it. Every request carries a privilege level, which the block screens before acting.

A fold does not write the new digest. The block puts the register's present contents in front of the new digest, passes that double-width message to an external hash engine through a start/done handshake, and writes the returned digest into the same register. The block handles one fold at a time. While a fold is in flight it signals busy and ignores new requests. Reads are always served from the bank itself, so a register under update reads its old value until the writeback edge. The registers are plain flops: power loss or the hard reset clears all of them.

Top module: `meas_reg_bank`

## Requirements
- R1: One cycle after a fold request is accepted, `hashStart` is high and `hashMsg` carries the register's old value in bits [511:256] and the request digest in bits [255:0].
- R2: The cycle after `hashDone` is seen, the block stays busy. One cycle later `busy` is low and the register holds `hashResult`.
- R3: After the hard reset (`rstN` low), every register reads zero and `busy` and `errFlag` are low.
- R4: A clear request (`reqOp`=1) to a dynamic register (index 8 to 15) with a legal privilege zeroes that register by the next cycle without raising `busy`.
- R5: A clear request to a static register (index 0 to 7) raises `errFlag` for one cycle after the request and leaves the register unchanged.
- R6: Privilege levels 0 to 4 and 32 to 255 are legal. A request at levels 5 to 31 raises `errFlag` the next cycle, starts no hash and changes no register.
- R7: `busy` is high from the cycle after a fold is accepted until the writeback completes. Requests presented while busy are ignored: no error, no hash start and no register change.
- R8: While a fold is pending, a read of its register returns the value from before the update.
- R9: `hashStart` lasts exactly one cycle per fold. `hashMsg` stays stable while the fold is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Hard reset, active low, asynchronous; clears every register |
| reqValid | input | 1 | Request strobe, sampled when not busy |
| reqOp | input | 1 | 0 = fold digest in, 1 = clear register |
| reqIndex | input | 4 | Target register |
| reqDigest | input | 256 | Digest to fold in |
| reqLocality | input | 8 | Privilege level of the request |
| busy | output | 1 | A fold is in flight |
| errFlag | output | 1 | One-cycle pulse for a rejected request |
| rdIndex | input | 4 | Read select |
| rdData | output | 256 | Contents of the selected register |
| hashStart | output | 1 | One-cycle start pulse to the hash engine |
| hashMsg | output | 512 | Old value followed by new digest |
| hashDone | input | 1 | Hash engine result valid |
| hashResult | input | 256 | Digest returned by the hash engine |

## Verification
The bench stands in for the hash engine with an asymmetric mixing function. It varies the engine latency, so a design that puts the two halves of the message in the wrong order, or that writes back before done, leaves wrong register contents. Reads are taken while a fold waits, which exposes a design that forwards the pending result early. The bench also sends clear and fold requests while the block is busy, and a design that fails to ignore them zeroes or corrupts registers. Clear requests aimed at the boundary between the static and dynamic classes, and privilege levels at 4, 5, 31 and 32, test the edges of the clearing rule and the privilege rule.

// File: rtl/meas_reg_bank_pkg.sv
package meas_reg_bank_pkg;

  localparam logic OP_FOLD  = 1'b0;
  localparam logic OP_CLEAR = 1'b1;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_START,
    ST_WAIT,
    ST_WRITE
  } ctlState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic captureReq;    // latch index and build hash message
    logic captureResult; // latch digest returned by engine
    logic writeBack;     // commit latched digest to bank
    logic clearEn;       // zero the requested register
  } dpStrobes_t;

endpackage

// File: rtl/meas_reg_bank_ctrl.sv
module meas_reg_bank_ctrl
  import meas_reg_bank_pkg::*;
#(
  parameter int NUM_REGS     = 16,
  parameter int STATIC_COUNT = 8,
  parameter int LOC_W        = 8,
  parameter int BASIC_MAX    = 4,
  parameter int EXT_MIN      = 32,
  localparam int IDX_W       = $clog2(NUM_REGS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             reqOp,
  input  logic [IDX_W-1:0] reqIndex,
  input  logic [LOC_W-1:0] reqLocality,
  input  logic             hashDone,
  output logic             hashStart,
  output logic             busy,
  output logic             errFlag,
  output dpStrobes_t       strobes
);

  ctlState_t state, stateNext;

  logic localityOk;
  logic isStatic;
  logic accept;
  logic foldGo;
  logic clearGo;
  logic rejectNow;

  assign localityOk = (reqLocality <= LOC_W'(BASIC_MAX)) ||
                      (reqLocality >= LOC_W'(EXT_MIN));
  assign isStatic   = reqIndex < IDX_W'(STATIC_COUNT);
  assign accept     = reqValid && (state == ST_IDLE);
  assign foldGo     = accept && (reqOp == OP_FOLD) && localityOk;
  assign clearGo    = accept && (reqOp == OP_CLEAR) && localityOk && !isStatic;
  assign rejectNow  = accept && !foldGo && !clearGo;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:  if (foldGo) stateNext = ST_START;
      ST_START: stateNext = ST_WAIT;
      ST_WAIT:  if (hashDone) stateNext = ST_WRITE;
      ST_WRITE: stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      errFlag <= 1'b0;
    end else begin
      state   <= stateNext;
      errFlag <= rejectNow;
    end
  end

  always_comb begin
    strobes               = '0;
    strobes.captureReq    = foldGo;
    strobes.clearEn       = clearGo;
    strobes.captureResult = (state == ST_WAIT) && hashDone;
    strobes.writeBack     = (state == ST_WRITE);
  end

  assign hashStart = (state == ST_START);
  assign busy      = (state != ST_IDLE);

endmodule

// File: rtl/meas_reg_bank_dp.sv
module meas_reg_bank_dp
  import meas_reg_bank_pkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter int REG_W    = 256,
  localparam int IDX_W   = $clog2(NUM_REGS),
  localparam int MSG_W   = 2 * REG_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobes_t       strobes,
  input  logic [IDX_W-1:0] reqIndex,
  input  logic [REG_W-1:0] reqDigest,
  input  logic [REG_W-1:0] hashResult,
  input  logic [IDX_W-1:0] rdIndex,
  output logic [REG_W-1:0] rdData,
  output logic [MSG_W-1:0] hashMsg
);

  logic [REG_W-1:0] bank [NUM_REGS];
  logic [IDX_W-1:0] pendIndex;
  logic [REG_W-1:0] resultReg;

  // one write port per register, selected by index
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic hitClear;
    logic hitWrite;
    assign hitClear = strobes.clearEn   && (reqIndex  == IDX_W'(g));
    assign hitWrite = strobes.writeBack && (pendIndex == IDX_W'(g));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)         bank[g] <= '0;
      else if (hitClear) bank[g] <= '0;
      else if (hitWrite) bank[g] <= resultReg;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendIndex <= '0;
      hashMsg   <= '0;
      resultReg <= '0;
    end else begin
      if (strobes.captureReq) begin
        pendIndex <= reqIndex;
        hashMsg   <= {bank[reqIndex], reqDigest};
      end
      if (strobes.captureResult) resultReg <= hashResult;
    end
  end

  assign rdData = bank[rdIndex];

endmodule

// File: rtl/meas_reg_bank.sv
module meas_reg_bank
  import meas_reg_bank_pkg::*;
#(
  parameter int NUM_REGS     = 16,
  parameter int REG_W        = 256,
  parameter int STATIC_COUNT = 8,
  parameter int LOC_W        = 8,
  parameter int BASIC_MAX    = 4,
  parameter int EXT_MIN      = 32,
  localparam int IDX_W       = $clog2(NUM_REGS),
  localparam int MSG_W       = 2 * REG_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             reqOp,
  input  logic [IDX_W-1:0] reqIndex,
  input  logic [REG_W-1:0] reqDigest,
  input  logic [LOC_W-1:0] reqLocality,
  output logic             busy,
  output logic             errFlag,
  input  logic [IDX_W-1:0] rdIndex,
  output logic [REG_W-1:0] rdData,
  output logic             hashStart,
  output logic [MSG_W-1:0] hashMsg,
  input  logic             hashDone,
  input  logic [REG_W-1:0] hashResult
);

  dpStrobes_t strobes;

  meas_reg_bank_ctrl #(
    .NUM_REGS(NUM_REGS), .STATIC_COUNT(STATIC_COUNT), .LOC_W(LOC_W),
    .BASIC_MAX(BASIC_MAX), .EXT_MIN(EXT_MIN)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
    .reqIndex(reqIndex), .reqLocality(reqLocality), .hashDone(hashDone),
    .hashStart(hashStart), .busy(busy), .errFlag(errFlag), .strobes(strobes)
  );

  meas_reg_bank_dp #(
    .NUM_REGS(NUM_REGS), .REG_W(REG_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .reqIndex(reqIndex),
    .reqDigest(reqDigest), .hashResult(hashResult), .rdIndex(rdIndex),
    .rdData(rdData), .hashMsg(hashMsg)
  );

endmodule

// File: rtl/meas_reg_bank_checker.sv
module meas_reg_bank_checker #(
  parameter int NUM_REGS     = 16,
  parameter int REG_W        = 256,
  parameter int STATIC_COUNT = 8,
  parameter int LOC_W        = 8,
  parameter int BASIC_MAX    = 4,
  parameter int EXT_MIN      = 32,
  localparam int IDX_W       = $clog2(NUM_REGS),
  localparam int MSG_W       = 2 * REG_W
) (
  input logic             clk,
  input logic             rstN,
  input logic             reqValid,
  input logic             reqOp,
  input logic [IDX_W-1:0] reqIndex,
  input logic [LOC_W-1:0] reqLocality,
  input logic             busy,
  input logic             errFlag,
  input logic             hashStart,
  input logic [MSG_W-1:0] hashMsg,
  input logic             hashDone
);

  logic locLegal;
  assign locLegal = (reqLocality <= LOC_W'(BASIC_MAX)) ||
                    (reqLocality >= LOC_W'(EXT_MIN));

  assert_fold_starts_R1: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !busy && !reqOp && locLegal) |=> (hashStart && busy));

  assert_done_then_writeback_R2: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !hashStart && hashDone) |=> (busy && !hashStart));

  assert_static_clear_rejected_R5: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !busy && reqOp && (reqIndex < IDX_W'(STATIC_COUNT))) |=> (errFlag && !busy));

  assert_bad_locality_R6: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !busy && !locLegal) |=> (errFlag && !hashStart));

  assert_busy_ignores_R7: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> !errFlag);

  assert_start_single_R9: assert property (@(posedge clk) disable iff (!rstN)
    hashStart |=> !hashStart);

  assert_msg_stable_R9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !hashStart) |-> $stable(hashMsg));

endmodule

bind meas_reg_bank meas_reg_bank_checker #(
  .NUM_REGS(NUM_REGS), .REG_W(REG_W), .STATIC_COUNT(STATIC_COUNT),
  .LOC_W(LOC_W), .BASIC_MAX(BASIC_MAX), .EXT_MIN(EXT_MIN)
) u_checker (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
  .reqIndex(reqIndex), .reqLocality(reqLocality), .busy(busy),
  .errFlag(errFlag), .hashStart(hashStart), .hashMsg(hashMsg),
  .hashDone(hashDone)
);

// File: tb/meas_reg_bank_test.sv
`timescale 1ns/1ps
module meas_reg_bank_test;

  localparam int NR = 16;
  localparam int RW = 256;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0;
  logic          reqOp = 1'b0;
  logic [3:0]    reqIndex = '0;
  logic [RW-1:0] reqDigest = '0;
  logic [7:0]    reqLocality = '0;
  logic          busy;
  logic          errFlag;
  logic [3:0]    rdIndex = '0;
  logic [RW-1:0] rdData;
  logic          hashStart;
  logic [2*RW-1:0] hashMsg;
  logic          hashDone = 1'b0;
  logic [RW-1:0] hashResult = '0;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;
  logic [RW-1:0] mdl [NR];

  always #10 clk = ~clk;

  meas_reg_bank uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
    .reqIndex(reqIndex), .reqDigest(reqDigest), .reqLocality(reqLocality),
    .busy(busy), .errFlag(errFlag), .rdIndex(rdIndex), .rdData(rdData),
    .hashStart(hashStart), .hashMsg(hashMsg), .hashDone(hashDone),
    .hashResult(hashResult)
  );

  function automatic logic [RW-1:0] fakeHash(input logic [2*RW-1:0] m);
    logic [RW-1:0] a, b;
    a = m[2*RW-1:RW];
    b = m[RW-1:0];
    return {a[RW-4:0], a[RW-1:RW-3]} ^ (b + {8{32'h9e3779b9}});
  endfunction

  function automatic logic [RW-1:0] randWord();
    logic [RW-1:0] w;
    for (int k = 0; k < RW/32; k++) w[k*32 +: 32] = $urandom;
    return w;
  endfunction

  function automatic bit locOk(input logic [7:0] l);
    return (l <= 8'd4) || (l >= 8'd32);
  endfunction

  task automatic check(input bit ok, input string req, input logic [RW-1:0] act,
                       input logic [RW-1:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic readCheck(input int idx, input string req);
    rdIndex = idx[3:0];
    #1;
    check(rdData === mdl[idx], req, rdData, mdl[idx]);
  endtask

  task automatic issue(input logic op, input int idx, input logic [RW-1:0] dig,
                       input logic [7:0] loc);
    @(negedge clk);
    reqValid = 1'b1; reqOp = op; reqIndex = idx[3:0];
    reqDigest = dig; reqLocality = loc;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  // fold with engine latency lat; optionally poke requests while busy
  task automatic doFold(input int idx, input logic [RW-1:0] dig, input logic [7:0] loc,
                        input int lat, input bit poke);
    logic [2*RW-1:0] expMsg;
    logic [RW-1:0] res;
    int pokeIdx;
    expMsg = {mdl[idx], dig};
    issue(1'b0, idx, dig, loc);
    check(busy === 1'b1, "R7 busy after accept", {255'd0, busy}, 256'd1);
    check(hashStart === 1'b1, "R1 start pulse", {255'd0, hashStart}, 256'd1);
    check(hashMsg[2*RW-1:RW] === mdl[idx], "R1 old value upper half", hashMsg[2*RW-1:RW], mdl[idx]);
    check(hashMsg[RW-1:0] === dig, "R1 digest lower half", hashMsg[RW-1:0], dig);
    check(errFlag === 1'b0, "R6 legal locality no error", {255'd0, errFlag}, 256'd0);
    @(negedge clk);
    check(hashStart === 1'b0, "R9 single start", {255'd0, hashStart}, 256'd0);
    readCheck(idx, "R8 read while pending");
    pokeIdx = (idx >= 8) ? idx : 12;
    if (poke) begin
      reqValid = 1'b1; reqOp = 1'b1; reqIndex = pokeIdx[3:0]; reqLocality = 8'd0;
      @(negedge clk);
      reqValid = 1'b1; reqOp = 1'b0; reqIndex = 4'd3; reqLocality = 8'd10;
      @(negedge clk);
      reqValid = 1'b0;
      check(errFlag === 1'b0, "R7 busy ignores requests", {255'd0, errFlag}, 256'd0);
      check(hashStart === 1'b0, "R7 no second start", {255'd0, hashStart}, 256'd0);
    end
    repeat (lat) @(negedge clk);
    check(hashMsg === expMsg, "R9 message stable", hashMsg[RW-1:0], expMsg[RW-1:0]);
    res = fakeHash(expMsg);
    hashDone = 1'b1; hashResult = res;
    @(negedge clk);
    hashDone = 1'b0; hashResult = randWord();
    check(busy === 1'b1, "R2 busy through writeback", {255'd0, busy}, 256'd1);
    readCheck(idx, "R8 old value before writeback");
    @(negedge clk);
    check(busy === 1'b0, "R2 busy drops", {255'd0, busy}, 256'd0);
    mdl[idx] = res;
    readCheck(idx, "R2 writeback value");
    if (poke) begin
      readCheck(pokeIdx, "R7 ignored clear left register");
      readCheck(3, "R7 ignored fold left register");
    end
  endtask

  task automatic doOther(input logic op, input int idx, input logic [RW-1:0] dig,
                         input logic [7:0] loc);
    bit expErr;
    expErr = !locOk(loc) || (op && idx < 8);
    issue(op, idx, dig, loc);
    if (!locOk(loc))
      check(errFlag === expErr, "R6 bad locality error", {255'd0, errFlag}, {255'd0, expErr});
    else if (op && idx < 8)
      check(errFlag === expErr, "R5 static clear error", {255'd0, errFlag}, {255'd0, expErr});
    else
      check(errFlag === expErr, "R4 dynamic clear no error", {255'd0, errFlag}, {255'd0, expErr});
    check(busy === 1'b0 && hashStart === 1'b0, "R6 no hash on reject or clear",
          {254'd0, busy, hashStart}, 256'd0);
    if (!expErr) begin
      mdl[idx] = '0;
      readCheck(idx, "R4 dynamic clear zeroes");
    end else begin
      readCheck(idx, expErr && !locOk(loc) ? "R6 unchanged" : "R5 unchanged");
    end
    @(negedge clk);
    check(errFlag === 1'b0, "R5 error is one cycle", {255'd0, errFlag}, 256'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 32'h5eed_1234;
    void'($urandom(seed));
    for (int i = 0; i < NR; i++) mdl[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R3 reset state
    begin
      bit allZero;
      allZero = 1;
      for (int i = 0; i < NR; i++) begin
        rdIndex = i[3:0]; #1;
        if (rdData !== '0) allZero = 0;
      end
      check(allZero, "R3 registers zero after reset", {255'd0, allZero}, 256'd1);
      check(busy === 1'b0 && errFlag === 1'b0, "R3 flags low after reset",
            {254'd0, busy, errFlag}, 256'd0);
    end

    // directed corners
    doFold(0, randWord(), 8'd0, 0, 0);
    doFold(0, randWord(), 8'd4, 3, 0);
    doFold(7, randWord(), 8'd32, 1, 0);
    doFold(8, randWord(), 8'd255, 2, 1);
    doFold(15, randWord(), 8'd2, 5, 1);
    doOther(1'b0, 5, randWord(), 8'd5);
    doOther(1'b0, 5, randWord(), 8'd31);
    doOther(1'b1, 7, '0, 8'd0);
    doOther(1'b1, 8, '0, 8'd0);
    doOther(1'b1, 15, '0, 8'd20);
    doFold(15, randWord(), 8'd33, 0, 0);
    doOther(1'b1, 15, '0, 8'd4);

    // constrained random mix
    for (int n = 0; n < 80; n++) begin
      int idx, kind;
      logic [7:0] loc;
      idx = $urandom_range(0, NR - 1);
      kind = $urandom_range(0, 9);
      if ($urandom_range(0, 5) == 0) loc = 8'($urandom_range(5, 31));
      else if ($urandom_range(0, 1) == 0) loc = 8'($urandom_range(0, 4));
      else loc = 8'($urandom_range(32, 255));
      if (kind < 6 && locOk(loc))
        doFold(idx, randWord(), loc, $urandom_range(0, 6), $urandom_range(0, 3) == 0);
      else
        doOther(kind >= 6, idx, randWord(), loc);
    end

    // final sweep of the bank
    for (int i = 0; i < NR; i++) readCheck(i, "R2 final bank contents");

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule